// File: doc/BRIEF.md
# Linear Delay Model Evaluator

This block tracks a first-order geometric delay, offset plus rate times frame index, with one evaluation per transform frame rather than one per sample. Software writes an offset, a rate and a curvature coefficient into shadow registers at any time. A pulse at the start of an integration copies the shadow set into the active set and sets a delay accumulator to the offset. Each frame-step pulse then emits the current delay and adds the rate to the accumulator.

Every result is split at a fixed binary point into two fields. The whole-sample part sets the address of the first sample that the integration uses. The eight bits just below it form a phase index in steps of 1/256 sample. The block also flags when the whole-sample part moves between two steps of the same integration. Downstream logic then skips or repeats one sample and adds a quarter turn to its phase model. The curvature coefficient is kept but takes no part in the arithmetic.

Top module: `dly_poly_eval`

## Requirements
- R1: While and after a synchronous reset, with no frame step yet issued, out_vld is 0, out_roll is 00, and out_int and out_frac are 0.
- R2: Each cycle with frame_step high produces exactly one out_vld pulse, two cycles later. out_vld is 0 in every other cycle.
- R3: out_int carries delay bits [COEF_W-1:FRAC_W] (bits 31:16 with default parameters). The first step after integ_start reports the offset coefficient loaded by that start.
- R4: out_frac carries delay bits [FRAC_W-1:FRAC_W-8] (bits 15:8 by default): the fractional delay in units of 1/256 sample.
- R5: Each later step in an integration reports the previous delay plus the rate coefficient, which is two's complement. The sum wraps modulo 2^COEF_W.
- R6: out_roll is 01 (skip) when out_int rose against the previous step of the same integration and 10 (repeat) when it fell. It is 00 when out_int is unchanged and in every cycle without out_vld. The change is the integer difference taken modulo 2^(COEF_W-FRAC_W) as a signed value, so 0xFFFF to 0x0000 counts as a rise.
- R7: The first step after integ_start, and the first step after reset, always report out_roll 00.
- R8: A write (cfg_we high) with cfg_sel 0 sets the offset, 1 the rate and 2 the curvature. A write lands in a shadow register and affects results only after the next integ_start. A write in the same cycle as integ_start waits for the following start.
- R9: The curvature coefficient is stored and reloaded with the others but never changes any output.
- R10: When integ_start and frame_step are high in the same cycle, that step uses the newly loaded coefficients and reports the new offset with out_roll 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 2 | Coefficient select: 0 offset, 1 rate, 2 curvature |
| cfg_wdata | input | COEF_W | Coefficient value |
| integ_start | input | 1 | Integration start pulse; loads shadow set, sets accumulator to offset |
| frame_step | input | 1 | One pulse per transform frame |
| out_vld | output | 1 | Result strobe, two cycles after frame_step |
| out_int | output | COEF_W-FRAC_W | Whole-sample delay |
| out_frac | output | PHASE_W | Fractional delay, 1/256 sample units |
| out_roll | output | 2 | Rollover: 00 none, 01 skip, 10 repeat |

## Verification
A corrupted accumulator shows up in out_int or out_frac on the very next valid result, two cycles after the step that reads it. The error persists for the rest of the integration, because every later value is built on it. A stale previous-integer register shows up as a wrong or missing skip/repeat code on the next step that crosses a sample boundary, or as a spurious code on a step that does not. Shadow and active registers that are swapped or loaded too early show up in the first result after a mid-integration write, before the next start pulse.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  typedef enum logic [1:0] {
    ROLL_NONE   = 2'b00,
    ROLL_SKIP   = 2'b01,
    ROLL_REPEAT = 2'b10
  } roll_e;

  localparam int CI_OFFSET = 0;
  localparam int CI_RATE   = 1;
  localparam int CI_CURV   = 2;
  localparam int CI_COUNT  = 3;
endpackage

// File: rtl/dpe_coef_bank.sv
module dpe_coef_bank #(
  parameter int COEF_W   = 32,
  parameter int NUM_COEF = 3,
  parameter int SEL_W    = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  wr_sel,
  input  logic [COEF_W-1:0]                 wr_data,
  input  logic                              load,
  output logic [NUM_COEF-1:0][COEF_W-1:0]   shadow_o,
  output logic [NUM_COEF-1:0][COEF_W-1:0]   active_o
);
  for (genvar g = 0; g < NUM_COEF; g++) begin : g_coef
    logic [COEF_W-1:0] shadow_q;
    logic [COEF_W-1:0] active_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (wr_en && (wr_sel == SEL_W'(g))) shadow_q <= wr_data;
        if (load) active_q <= shadow_q;
      end
    end

    assign shadow_o[g] = shadow_q;
    assign active_o[g] = active_q;
  end
endmodule

// File: rtl/dpe_accum.sv
module dpe_accum #(
  parameter int COEF_W  = 32,
  parameter int FRAC_W  = 16,
  parameter int PHASE_W = 8,
  localparam int KEEP_W = COEF_W - FRAC_W + PHASE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [COEF_W-1:0] d0_ld,
  input  logic [COEF_W-1:0] rate_ld,
  input  logic [COEF_W-1:0] rate_run,
  output logic              s1_vld,
  output logic              s1_first,
  output logic [KEEP_W-1:0] s1_val
);
  logic [COEF_W-1:0] acc_q;
  logic              first_pend_q;
  logic [COEF_W-1:0] base;
  logic [COEF_W-1:0] rate_use;

  always_comb begin
    base     = load ? d0_ld   : acc_q;
    rate_use = load ? rate_ld : rate_run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q        <= '0;
      first_pend_q <= 1'b1;
      s1_vld       <= 1'b0;
      s1_first     <= 1'b0;
      s1_val       <= '0;
    end else begin
      s1_vld <= step;
      if (step) begin
        s1_val       <= base[COEF_W-1:FRAC_W-PHASE_W];
        s1_first     <= load | first_pend_q;
        acc_q        <= base + rate_use;
        first_pend_q <= 1'b0;
      end else if (load) begin
        acc_q        <= d0_ld;
        first_pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpe_split.sv
module dpe_split import dpe_pkg::*; #(
  parameter int COEF_W  = 32,
  parameter int FRAC_W  = 16,
  parameter int PHASE_W = 8,
  localparam int INT_W  = COEF_W - FRAC_W,
  localparam int KEEP_W = INT_W + PHASE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s1_vld,
  input  logic               s1_first,
  input  logic [KEEP_W-1:0]  s1_val,
  output logic               out_vld,
  output logic [INT_W-1:0]   out_int,
  output logic [PHASE_W-1:0] out_frac,
  output logic [1:0]         out_roll
);
  logic [INT_W-1:0] prev_int_q;
  logic [INT_W-1:0] cur_int;
  logic [INT_W-1:0] diff;
  roll_e            roll_nx;

  always_comb begin
    cur_int = s1_val[KEEP_W-1:PHASE_W];
    diff    = cur_int - prev_int_q;
    roll_nx = ROLL_NONE;
    if (s1_vld && !s1_first && (diff != '0))
      roll_nx = diff[INT_W-1] ? ROLL_REPEAT : ROLL_SKIP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld    <= 1'b0;
      out_int    <= '0;
      out_frac   <= '0;
      out_roll   <= ROLL_NONE;
      prev_int_q <= '0;
    end else begin
      out_vld  <= s1_vld;
      out_roll <= roll_nx;
      if (s1_vld) begin
        out_int    <= cur_int;
        out_frac   <= s1_val[PHASE_W-1:0];
        prev_int_q <= cur_int;
      end
    end
  end
endmodule

// File: rtl/dly_poly_eval.sv
module dly_poly_eval import dpe_pkg::*; #(
  parameter int COEF_W  = 32,
  parameter int FRAC_W  = 16,
  parameter int PHASE_W = 8,
  parameter int SEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic [COEF_W-1:0]         cfg_wdata,
  input  logic                      integ_start,
  input  logic                      frame_step,
  output logic                      out_vld,
  output logic [COEF_W-FRAC_W-1:0]  out_int,
  output logic [PHASE_W-1:0]        out_frac,
  output logic [1:0]                out_roll
);
  localparam int INT_W  = COEF_W - FRAC_W;
  localparam int KEEP_W = INT_W + PHASE_W;

  logic [CI_COUNT-1:0][COEF_W-1:0] coef_sh;
  logic [CI_COUNT-1:0][COEF_W-1:0] coef_act;
  logic                            s1_vld;
  logic                            s1_first;
  logic [KEEP_W-1:0]               s1_val;

  dpe_coef_bank #(
    .COEF_W  (COEF_W),
    .NUM_COEF(CI_COUNT),
    .SEL_W   (SEL_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .load    (integ_start),
    .shadow_o(coef_sh),
    .active_o(coef_act)
  );

  dpe_accum #(
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W),
    .PHASE_W(PHASE_W)
  ) u_accum (
    .clk     (clk),
    .rst     (rst),
    .load    (integ_start),
    .step    (frame_step),
    .d0_ld   (coef_sh[CI_OFFSET]),
    .rate_ld (coef_sh[CI_RATE]),
    .rate_run(coef_act[CI_RATE]),
    .s1_vld  (s1_vld),
    .s1_first(s1_first),
    .s1_val  (s1_val)
  );

  dpe_split #(
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W),
    .PHASE_W(PHASE_W)
  ) u_split (
    .clk     (clk),
    .rst     (rst),
    .s1_vld  (s1_vld),
    .s1_first(s1_first),
    .s1_val  (s1_val),
    .out_vld (out_vld),
    .out_int (out_int),
    .out_frac(out_frac),
    .out_roll(out_roll)
  );
endmodule

// File: rtl/dly_poly_eval_chk.sv
module dly_poly_eval_chk #(
  parameter int INT_W  = 16,
  parameter int COEF_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_step,
  input logic              integ_start,
  input logic              out_vld,
  input logic [INT_W-1:0]  out_int,
  input logic [1:0]        out_roll,
  input logic [COEF_W-1:0] d2_act
);
  logic [INT_W-1:0] last_int_q;

  always_ff @(posedge clk) begin
    if (rst) last_int_q <= '0;
    else if (out_vld) last_int_q <= out_int;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_step, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> out_vld); // R2
  AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(frame_step, 2)); // R2
  AST_ROLL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_roll == 2'b00)); // R6
  AST_ROLL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_roll)); // R6
  AST_ROLL_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_roll != 2'b00) |-> (out_int != last_int_q)); // R6
  AST_CURV_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(integ_start) |-> $stable(d2_act)); // R9
endmodule

bind dly_poly_eval dly_poly_eval_chk #(
  .INT_W (COEF_W - FRAC_W),
  .COEF_W(COEF_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_step (frame_step),
  .integ_start(integ_start),
  .out_vld    (out_vld),
  .out_int    (out_int),
  .out_roll   (out_roll),
  .d2_act     (coef_act[dpe_pkg::CI_CURV])
);

// File: tb/dly_poly_eval_tb.sv
module dly_poly_eval_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COEF_W = 32;
  localparam int FRAC_W = 16;
  localparam int INT_W  = COEF_W - FRAC_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic [COEF_W-1:0] cfg_wdata = '0;
  logic              integ_start = 1'b0;
  logic              frame_step = 1'b0;
  logic              out_vld;
  logic [INT_W-1:0]  out_int;
  logic [7:0]        out_frac;
  logic [1:0]        out_roll;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [COEF_W-1:0] m_sh  [3];
  logic [COEF_W-1:0] m_act [3];
  logic [COEF_W-1:0] m_acc   = '0;
  logic [INT_W-1:0]  m_prev  = '0;
  bit                m_first = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_poly_eval u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .integ_start(integ_start), .frame_step(frame_step), .out_vld(out_vld),
    .out_int(out_int), .out_frac(out_frac), .out_roll(out_roll)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mdl_step(output logic [INT_W-1:0] ei, output logic [7:0] ef,
                          output logic [1:0] er);
    logic [INT_W-1:0] d;
    ei = m_acc[COEF_W-1:FRAC_W];
    ef = m_acc[FRAC_W-1:FRAC_W-8];
    d  = ei - m_prev;
    if (m_first || d == '0) er = 2'b00;
    else if (d[INT_W-1])   er = 2'b10;
    else                   er = 2'b01;
    m_prev  = ei;
    m_first = 1'b0;
    m_acc   = m_acc + m_act[1];
  endtask

  task automatic mdl_load();
    for (int i = 0; i < 3; i++) m_act[i] = m_sh[i];
    m_acc   = m_act[0];
    m_first = 1'b1;
  endtask

  task automatic wait_result(string tag, logic [INT_W-1:0] ei, logic [7:0] ef, logic [1:0] er);
    @(negedge clk);
    frame_step  = 1'b0;
    integ_start = 1'b0;
    check({"R2 early vld ", tag}, out_vld, 1'b0);
    @(negedge clk);
    check({"R2 vld ", tag}, out_vld, 1'b1);
    check({"R3/R5 int ", tag}, out_int, ei);
    check({"R4 frac ", tag}, out_frac, ef);
    check({"R6 roll ", tag}, out_roll, er);
    @(negedge clk);
    check({"R2 single vld ", tag}, out_vld, 1'b0);
    check({"R6 quiet roll ", tag}, out_roll, 2'b00);
  endtask

  task automatic step_chk(string tag);
    logic [INT_W-1:0] ei; logic [7:0] ef; logic [1:0] er;
    mdl_step(ei, ef, er);
    @(negedge clk);
    frame_step = 1'b1;
    wait_result(tag, ei, ef, er);
  endtask

  task automatic wr(int sel, logic [COEF_W-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_sh[sel] = v;
  endtask

  task automatic start();
    @(negedge clk);
    integ_start = 1'b1;
    @(negedge clk);
    integ_start = 1'b0;
    mdl_load();
  endtask

  task automatic t_reset();
    check("R1 vld", out_vld, 1'b0);
    check("R1 roll", out_roll, 2'b00);
    check("R1 int", out_int, '0);
    check("R1 frac", out_frac, '0);
  endtask

  task automatic t_ramp();
    wr(0, 32'h0005_8000);
    wr(1, 32'h0000_4000);
    start();
    for (int i = 0; i < 7; i++) step_chk("ramp R7 first no roll, R6 skip");
  endtask

  task automatic t_down();
    wr(0, 32'h0010_1000);
    wr(1, 32'hFFFF_D000);
    start();
    for (int i = 0; i < 6; i++) step_chk("down R6 repeat");
  endtask

  task automatic t_shadow();
    logic [COEF_W-1:0] old_sh0;
    wr(0, 32'h0020_0000);
    wr(1, 32'h0000_8000);
    start();
    step_chk("R8 pre-write");
    wr(0, 32'h0100_0000);
    wr(1, 32'h0001_0000);
    step_chk("R8 write held in shadow");
    step_chk("R8 write held in shadow 2");
    start();
    check("R8 new offset loaded", m_acc, 32'h0100_0000);
    step_chk("R8 new set");
    step_chk("R8 new rate");
    old_sh0 = m_sh[0];
    @(negedge clk);
    integ_start = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0042_0000;
    @(negedge clk);
    integ_start = 1'b0; cfg_we = 1'b0;
    mdl_load();
    m_sh[0] = 32'h0042_0000;
    check("R8 same-cycle write deferred", m_act[0], old_sh0);
    step_chk("R8 same-cycle write deferred");
    start();
    step_chk("R8 deferred write now active");
  endtask

  task automatic t_curv();
    wr(0, 32'h0005_8000);
    wr(1, 32'h0000_4000);
    wr(2, 32'hDEAD_BEEF);
    start();
    for (int i = 0; i < 5; i++) step_chk("R9 curvature ignored");
    wr(2, 32'h7FFF_0001);
    start();
    step_chk("R9 curvature ignored 2");
    check("R9 first value equals offset", {32'h0, 16'h0005, 8'h80}, {32'h0, out_int, out_frac});
  endtask

  task automatic t_wrap();
    wr(0, 32'hFFFF_C000);
    wr(1, 32'h0000_2000);
    wr(2, 32'h0);
    start();
    for (int i = 0; i < 4; i++) step_chk("R5/R6 wrap skip");
  endtask

  task automatic t_same_cycle();
    logic [INT_W-1:0] ei; logic [7:0] ef; logic [1:0] er;
    wr(0, 32'h0300_4400);
    wr(1, 32'h0000_1000);
    @(negedge clk);
    integ_start = 1'b1;
    frame_step  = 1'b1;
    mdl_load();
    mdl_step(ei, ef, er);
    check("R10 expected is new offset", {ei, ef}, 24'h0300_44);
    wait_result("R10 start+step", ei, ef, er);
    step_chk("R10 follow-on");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_ramp();
    t_down();
    t_shadow();
    t_curv();
    t_wrap();
    t_same_cycle();
    repeat (3) @(negedge clk);
    check("R2 idle no vld", out_vld, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule